// File: doc/BRIEF.md
# Colour Palette Lookup Register File

This block holds a table of colour entries that a host loads and reads back one byte at a time, and that pixel logic reads as packed 24-bit colours. Each entry has three 6-bit components, in the order red, green, blue. The host sees three byte-wide registers behind one select field. One register sets the entry pointer for reads. One sets the entry pointer for writes. The third is a shared data register.

Each pointer has its own component counter. The counter steps through the three components of one entry and then moves on to the next entry. A write to the data register stores one component. On the third component of an entry, the block widens all three components to 8 bits and commits the packed colour into a second table. A pixel index input returns that colour combinationally.

Top module: `palette_dac`

## Requirements
- R1: A write with `host_sel`=2'b00 loads the read entry pointer from `host_wdata` and clears the read component counter.
- R2: A write with `host_sel`=2'b01 loads the write entry pointer from `host_wdata` and clears the write component counter.
- R3: A write with `host_sel`=2'b10 stores `host_wdata[5:0]` as component (write entry, write counter). Components are numbered 0 red, 1 green, 2 blue. The counter then steps 0→1→2. After component 2 it returns to 0 and the entry pointer increments, wrapping from the last entry to 0.
- R4: `host_rdata` always shows, zero-extended, the component at the read entry pointer and read counter. A pulse on `host_re` with `host_sel`=2'b10 advances the read pointer in the same way as R3. It leaves the write pointer unchanged.
- R5: Writing component 2 of an entry commits a packed colour for that entry. Red sits in [23:16], green in [15:8] and blue in [7:0]. Each 6-bit value c is widened to {c, c[0], c[0]}. The value appears on `pix_rgb` for that `pix_idx` from the clock edge of the commit onward.
- R6: Writing component 0 or 1 alone does not change the packed colour of the entry.
- R7: After reset, both pointers and both counters are 0, every component is 0 and every packed colour is 0.
- R8: Bits [7:6] of a data write have no effect on the stored component.
- R9: When `host_we` and `host_re` are high in the same cycle, the read strobe is ignored. A write with `host_sel`=2'b11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (data register only) |
| host_sel | input | 2 | Register select: 00 read index, 01 write index, 10 data, 11 none |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Component at the read pointer, zero-extended |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Packed colour for `pix_idx` |

## Verification
The bench checks a directed triple made of all ones, all zeros and a mixed pattern, so that each component lane and both low-bit copies in the widening can be told apart. It also loads single and double components, which separates a commit on the third write from a commit on every write. Pointers are started at the last entry, which shows whether the entry wraps and whether the counter resets after blue. A long random mix of index loads, data writes, data reads and lookups interleaves the two pointers. This separates independent read and write state from shared state. Writes with junk in the top bits, and cycles with both strobes high, test the ignore rules.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        SEL_RIDX = 2'b00,
        SEL_WIDX = 2'b01,
        SEL_DATA = 2'b10,
        SEL_NONE = 2'b11
    } port_sel_e;

    localparam int unsigned COMPS     = 3;
    localparam logic [1:0]  LAST_COMP = 2'd2;
endpackage

// File: rtl/pal_ptr.sv
module pal_ptr #(
    parameter int unsigned IDXW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [IDXW-1:0] load_val,
    input  logic            step,
    output logic [IDXW-1:0] ent,
    output logic [1:0]      sub
);
    import pal_pkg::*;

    typedef struct packed {
        logic [IDXW-1:0] ent;
        logic [1:0]      sub;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ent = load_val;
            st_d.sub = 2'd0;
        end else if (step) begin
            if (st_q.sub == LAST_COMP) begin
                st_d.sub = 2'd0;
                st_d.ent = st_q.ent + 1'b1;
            end else begin
                st_d.sub = st_q.sub + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent = st_q.ent;
    assign sub = st_q.sub;
endmodule

// File: rtl/pal_comp_store.sv
module pal_comp_store #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned CW      = 6,
    localparam int unsigned IDXW   = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] w_ent,
    input  logic [1:0]      w_sub,
    input  logic [CW-1:0]   w_val,
    input  logic [IDXW-1:0] r_ent,
    input  logic [1:0]      r_sub,
    output logic [CW-1:0]   r_val,
    output logic [CW-1:0]   w_c0,
    output logic [CW-1:0]   w_c1
);
    import pal_pkg::*;

    logic [CW-1:0] red_q   [ENTRIES];
    logic [CW-1:0] green_q [ENTRIES];
    logic [CW-1:0] blue_q  [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                red_q[i]   <= '0;
                green_q[i] <= '0;
                blue_q[i]  <= '0;
            end
        end else if (we) begin
            case (w_sub)
                2'd0:    red_q[w_ent]   <= w_val;
                2'd1:    green_q[w_ent] <= w_val;
                2'd2:    blue_q[w_ent]  <= w_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (r_sub)
            2'd0:    r_val = red_q[r_ent];
            2'd1:    r_val = green_q[r_ent];
            2'd2:    r_val = blue_q[r_ent];
            default: r_val = '0;
        endcase
    end

    assign w_c0 = red_q[w_ent];
    assign w_c1 = green_q[w_ent];
endmodule

// File: rtl/pal_expand.sv
module pal_expand #(
    parameter int unsigned CW = 6,
    parameter int unsigned OW = 8
) (
    input  logic [CW-1:0] c,
    output logic [OW-1:0] e
);
    generate
        if (OW > CW) begin : g_widen
            assign e = {c, {(OW-CW){c[0]}}};
        end else begin : g_trunc
            assign e = c[CW-1 -: OW];
        end
    endgenerate
endmodule

// File: rtl/pal_rgb_table.sv
module pal_rgb_table #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned OW      = 8,
    localparam int unsigned IDXW   = $clog2(ENTRIES),
    localparam int unsigned RGBW   = 3 * OW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [IDXW-1:0] c_ent,
    input  logic [RGBW-1:0] c_rgb,
    input  logic [IDXW-1:0] look_idx,
    output logic [RGBW-1:0] look_rgb
);
    logic [RGBW-1:0] tab_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
        end else if (commit) begin
            tab_q[c_ent] <= c_rgb;
        end
    end

    assign look_rgb = tab_q[look_idx];
endmodule

// File: rtl/palette_dac.sv
module palette_dac #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned CW      = 6,
    parameter int unsigned OW      = 8,
    parameter int unsigned DW      = 8,
    localparam int unsigned IDXW   = $clog2(ENTRIES),
    localparam int unsigned RGBW   = 3 * OW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic            host_re,
    input  logic [1:0]      host_sel,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    input  logic [IDXW-1:0] pix_idx,
    output logic [RGBW-1:0] pix_rgb
);
    import pal_pkg::*;

    logic            ld_rd, ld_wr, dat_wr, dat_rd, commit;
    logic [IDXW-1:0] rd_ent, wr_ent;
    logic [1:0]      rd_sub, wr_sub;
    logic [CW-1:0]   r_val, w_c0, w_c1, w_val;
    logic [CW-1:0]   trip [COMPS];
    logic [OW-1:0]   wide [COMPS];
    logic [RGBW-1:0] rgb_new;

    // The write strobe has priority; a read is honoured only on its own.
    assign ld_rd  = host_we && (host_sel == SEL_RIDX);
    assign ld_wr  = host_we && (host_sel == SEL_WIDX);
    assign dat_wr = host_we && (host_sel == SEL_DATA);
    assign dat_rd = host_re && !host_we && (host_sel == SEL_DATA);
    assign w_val  = host_wdata[CW-1:0];
    assign commit = dat_wr && (wr_sub == LAST_COMP);

    pal_ptr #(.IDXW(IDXW)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .load(ld_rd), .load_val(host_wdata[IDXW-1:0]),
        .step(dat_rd), .ent(rd_ent), .sub(rd_sub)
    );

    pal_ptr #(.IDXW(IDXW)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .load(ld_wr), .load_val(host_wdata[IDXW-1:0]),
        .step(dat_wr), .ent(wr_ent), .sub(wr_sub)
    );

    pal_comp_store #(.ENTRIES(ENTRIES), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(dat_wr), .w_ent(wr_ent), .w_sub(wr_sub),
        .w_val(w_val), .r_ent(rd_ent), .r_sub(rd_sub), .r_val(r_val),
        .w_c0(w_c0), .w_c1(w_c1)
    );

    // Blue comes straight from the bus so the commit lands with the third write.
    assign trip[0] = w_c0;
    assign trip[1] = w_c1;
    assign trip[2] = w_val;

    generate
        for (genvar g = 0; g < COMPS; g++) begin : g_exp
            pal_expand #(.CW(CW), .OW(OW)) u_exp (.c(trip[g]), .e(wide[g]));
            assign rgb_new[RGBW-1-g*OW -: OW] = wide[g];
        end
    endgenerate

    pal_rgb_table #(.ENTRIES(ENTRIES), .OW(OW)) u_tab (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_ent(wr_ent), .c_rgb(rgb_new),
        .look_idx(pix_idx), .look_rgb(pix_rgb)
    );

    assign host_rdata = {{(DW-CW){1'b0}}, r_val};
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
    parameter int unsigned IDXW = 8,
    parameter int unsigned DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_we,
    input logic            host_re,
    input logic [1:0]      host_sel,
    input logic [DW-1:0]   host_wdata,
    input logic [IDXW-1:0] rd_ent,
    input logic [1:0]      rd_sub,
    input logic [IDXW-1:0] wr_ent,
    input logic [1:0]      wr_sub
);
    p_rd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'b00) |=> (rd_sub == 2'd0 && rd_ent == $past(host_wdata[IDXW-1:0])));

    p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'b01) |=> (wr_sub == 2'd0 && wr_ent == $past(host_wdata[IDXW-1:0])));

    p_sub_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sub != 2'd3) && (rd_sub != 2'd3));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 2'b10 && wr_sub == 2'd2) |=> (wr_sub == 2'd0 && wr_ent == $past(wr_ent) + 1'b1));

    p_rd_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we) |=> ($stable(wr_ent) && $stable(wr_sub)));

    p_we_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_re && host_sel == 2'b10) |=> ($stable(rd_ent) && $stable(rd_sub)));
endmodule

bind palette_dac pal_dac_chk #(.IDXW(IDXW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_sel(host_sel), .host_wdata(host_wdata), .rd_ent(rd_ent), .rd_sub(rd_sub),
    .wr_ent(wr_ent), .wr_sub(wr_sub)
);

// File: tb/palette_dac_bench.sv
module palette_dac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [1:0]  host_sel = 2'b11;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int total = 0, bad = 0;

    logic [5:0]  comp_m [256][3];
    logic [23:0] rgb_m  [256];
    logic [7:0]  rp = 0, wp = 0;
    int          rs = 0, ws = 0;

    always #10 clk = ~clk;

    palette_dac u_palette_dac (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    function automatic logic [7:0] widen(input logic [5:0] c);
        return {c, c[0], c[0]};
    endfunction

    function automatic logic [23:0] pack3(input logic [5:0] r, g, b);
        return {widen(r), widen(g), widen(b)};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_wr(input logic [1:0] s, input logic [7:0] v);
        case (s)
            2'b00: begin rp = v; rs = 0; end
            2'b01: begin wp = v; ws = 0; end
            2'b10: begin
                comp_m[wp][ws] = v[5:0];
                if (ws == 2) begin
                    rgb_m[wp] = pack3(comp_m[wp][0], comp_m[wp][1], comp_m[wp][2]);
                    ws = 0; wp = wp + 8'd1;
                end else ws++;
            end
            default: ;
        endcase
    endtask

    task automatic model_rd();
        if (rs == 2) begin rs = 0; rp = rp + 8'd1; end
        else rs++;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0; host_sel = 2'b11;
        model_wr(s, v);
    endtask

    task automatic rd(input string req);
        @(negedge clk);
        host_sel = 2'b10;
        #1 chk({24'd0, host_rdata}, {26'd0, comp_m[rp][rs]}, req);
        host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0; host_sel = 2'b11;
        model_rd();
    endtask

    task automatic look(input logic [7:0] i, input string req);
        pix_idx = i;
        #1 chk({8'd0, pix_rgb}, {8'd0, rgb_m[i]}, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 256; i++) begin
            rgb_m[i] = '0;
            for (int k = 0; k < 3; k++) comp_m[i][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        #1 chk({24'd0, host_rdata}, 32'd0, "R7 rdata after reset");
        look(8'd0, "R7 lookup 0 after reset");
        look(8'd200, "R7 lookup 200 after reset");

        // R2 R3 R5: full triple with distinct lanes
        wr(2'b01, 8'd5);
        wr(2'b10, 8'h3F);
        wr(2'b10, 8'h00);
        look(8'd5, "R6 two components do not commit");
        wr(2'b10, 8'h15);
        @(negedge clk);
        look(8'd5, "R5 packed colour entry 5");
        chk({8'd0, rgb_m[5]}, 32'h00FF0057, "R5 model expectation entry 5");

        // R6: single component into entry 7
        wr(2'b01, 8'd7);
        wr(2'b10, 8'h2A);
        look(8'd7, "R6 one component does not commit");

        // R1 R4: read back entry 5
        wr(2'b00, 8'd5);
        rd("R4 read red");
        rd("R4 read green");
        rd("R4 read blue");

        // R8: top bits dropped
        wr(2'b01, 8'd9);
        wr(2'b10, 8'hC1);
        wr(2'b10, 8'h80);
        wr(2'b10, 8'h7E);
        wr(2'b00, 8'd9);
        rd("R8 red low bits only");
        rd("R8 green low bits only");
        rd("R8 blue low bits only");
        look(8'd9, "R8 packed colour entry 9");

        // R3: wrap of the write pointer at the last entry
        wr(2'b01, 8'd255);
        wr(2'b10, 8'h01); wr(2'b10, 8'h02); wr(2'b10, 8'h03);
        wr(2'b10, 8'h04); wr(2'b10, 8'h05); wr(2'b10, 8'h06);
        look(8'd255, "R3 entry 255 committed");
        look(8'd0, "R3 write pointer wrapped to entry 0");

        // R4: read pointer wrap, write pointer untouched
        wr(2'b00, 8'd255);
        for (int k = 0; k < 4; k++) rd("R4 read across wrap");
        wr(2'b10, 8'h11);
        wr(2'b00, 8'd1);
        rd("R4 write pointer independent of reads");

        // R9: both strobes, and select 11
        wr(2'b00, 8'd0);
        @(negedge clk);
        host_we = 1'b1; host_re = 1'b1; host_sel = 2'b10; host_wdata = 8'h22;
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0; host_sel = 2'b11;
        model_wr(2'b10, 8'h22);
        rd("R9 read strobe ignored under write");
        wr(2'b11, 8'h33);
        rd("R9 select 11 has no effect");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            case (op)
                0:       wr(2'b00, 8'($urandom));
                1:       wr(2'b01, 8'($urandom));
                2, 3, 4: wr(2'b10, 8'($urandom));
                5, 6:    rd("R4 random read");
                7:       wr(2'b11, 8'($urandom));
                default: begin @(negedge clk); look(8'($urandom), "R5 random lookup"); end
            endcase
        end
        @(negedge clk);
        for (int i = 0; i < 256; i++) look(8'(i), "R5 final table scan");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule